// File: doc/BRIEF.md
# Kernel Segment Address Translator

This block sits beside the fetch and load/store path of a 64-bit processor core. It takes a 64-bit virtual address together with the core's privilege state, which is a two-bit privilege-level field (`priv_lvl`), an exception-level flag and an error-level flag. It decides whether the core runs with kernel rights and sorts the address into one of two fixed, unmapped kernel windows. An address in either window gets a 29-bit physical address by removing the window's base address. Any other address is passed back as needing the page-table path.

The block also owns the boot state. A synchronous cold reset loads the fetch pointer with the boot vector and sets the error-level flag. The first fetch therefore runs with kernel rights and lands on physical `0x1FC0_0000`, where the boot ROM lives. Software can later rewrite the three privilege fields and the fetch pointer through simple load strobes. A request strobe yields a response strobe exactly one cycle later, carrying the registered result.

Top module: `ksx_translator`

## Requirements
- R1: `kernel_mode` is high when `priv_lvl` is 2'b00, or when the exception-level flag is 1, or when the error-level flag is 1. Any one of these is enough. `priv_lvl` values 2'b01 and 2'b10 with both flags at 0 give `kernel_mode` low.
- R2: While `rst` is high at a clock edge, the next state is as follows: `fetch_pc` = 64'hFFFF_FFFF_BFC0_0000, `err_lvl` = 1, `priv_lvl` = 2'b10, the exception-level flag = 0 and `rsp_valid` = 0. The error-level flag alone therefore makes `kernel_mode` high after reset.
- R3: An address from 64'hFFFF_FFFF_A000_0000 through 64'hFFFF_FFFF_BFFF_FFFF, requested in kernel mode, responds with `rsp_ok`=1 and `rsp_cached`=0. `rsp_paddr` is the address minus 64'hFFFF_FFFF_A000_0000.
- R4: An address from 64'hFFFF_FFFF_8000_0000 through 64'hFFFF_FFFF_9FFF_FFFF, requested in kernel mode, responds with `rsp_ok`=1 and `rsp_cached`=1. `rsp_paddr` is the address minus 64'hFFFF_FFFF_8000_0000.
- R5: The boot vector 64'hFFFF_FFFF_BFC0_0000, read from `fetch_pc` after reset and requested, translates to physical 29'h1FC0_0000.
- R6: An address in either kernel window, requested while `kernel_mode` is low, responds with `rsp_addr_err`=1, `rsp_ok`=0, `rsp_cached`=0 and `rsp_paddr`=0.
- R7: Any address outside both windows responds with `rsp_needs_tlb`=1, `rsp_ok`=0, `rsp_addr_err`=0, `rsp_cached`=0 and `rsp_paddr`=0. This holds in every mode, including addresses whose upper 32 bits are not all ones.
- R8: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and only then. Back-to-back requests give back-to-back responses in the same order. Every response has exactly one of `rsp_ok`, `rsp_addr_err` and `rsp_needs_tlb` set.
- R9: `stat_we` loads all three privilege fields at the next edge, and `pc_we` loads `fetch_pc` from `pc_next` at the next edge. A request issued in the same cycle as a `stat_we` is judged by the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| stat_we | input | 1 | Load strobe for the privilege fields |
| stat_ksu | input | 2 | New privilege-level field (`priv_lvl`) |
| stat_exl | input | 1 | New exception-level flag |
| stat_erl | input | 1 | New error-level flag |
| pc_we | input | 1 | Load strobe for the fetch pointer |
| pc_next | input | 64 | New fetch pointer value |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 64 | Virtual address to translate |
| kernel_mode | output | 1 | Current kernel-rights decision |
| err_lvl | output | 1 | Current error-level flag |
| fetch_pc | output | 64 | Fetch pointer |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_addr_err | output | 1 | Kernel window reached without kernel rights |
| rsp_needs_tlb | output | 1 | Address lies outside the unmapped windows |
| rsp_cached | output | 1 | Hit was in the cached window |
| rsp_paddr | output | 29 | Physical address, zero unless `rsp_ok` |

## Verification
Both windows are probed at their first and last byte, and at the bytes just below the cached window and just above the uncached one. These probes show that the window compare is exact and that the base subtraction yields 0 and 0x1FFF_FFFF at the edges. Addresses with partial upper ones, including a 32-bit-looking 0x0000_0000_A000_0000, separate a full 64-bit compare from a lower-half one. Every privilege combination that grants or denies kernel rights is applied before kernel-window requests, which separates the three-way OR from a narrower condition. Runs of back-to-back requests straddling mode changes, and the boot vector read back from `fetch_pc`, confirm ordering, latency and the reset path.

// File: rtl/ksx_pkg.sv
package ksx_pkg;

    localparam int VA_W   = 64;
    localparam int PA_W   = 29;
    localparam int N_WIN  = 2;

    localparam logic [VA_W-1:0] COLD_VEC  = 64'hFFFF_FFFF_BFC0_0000;
    localparam logic [VA_W-1:0] WIN_C_LO  = 64'hFFFF_FFFF_8000_0000;
    localparam logic [VA_W-1:0] WIN_U_LO  = 64'hFFFF_FFFF_A000_0000;
    localparam logic [VA_W-1:0] WIN_SPAN  = 64'h0000_0000_2000_0000;

    localparam logic [1:0] PRIV_KERNEL = 2'b00;
    localparam logic [1:0] PRIV_BOOT   = 2'b10;

    typedef struct packed {
        logic [1:0] priv_lvl;
        logic       exc_lvl;
        logic       err_lvl;
    } mode_t;

    typedef struct packed {
        logic            ok;
        logic            addr_err;
        logic            needs_tlb;
        logic            cached;
        logic [PA_W-1:0] paddr;
    } xlat_t;

    function automatic logic [VA_W-1:0] win_base(input int idx);
        return (idx == 0) ? WIN_C_LO : WIN_U_LO;
    endfunction

    function automatic logic in_window(input logic [VA_W-1:0] a,
                                       input logic [VA_W-1:0] base);
        return (a >= base) && (a < (base + WIN_SPAN));
    endfunction

    function automatic logic has_kernel_rights(input mode_t m);
        return (m.priv_lvl == PRIV_KERNEL) || m.exc_lvl || m.err_lvl;
    endfunction

    function automatic logic [PA_W-1:0] strip_base(input logic [VA_W-1:0] a,
                                                   input logic [VA_W-1:0] base);
        logic [VA_W-1:0] diff;
        diff = a - base;
        return diff[PA_W-1:0];
    endfunction

endpackage

// File: rtl/ksx_mode_reg.sv
module ksx_mode_reg
    import ksx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  mode_t      mode_in,
    output mode_t      mode_q,
    output logic       kernel
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q.priv_lvl <= PRIV_BOOT;
            mode_q.exc_lvl  <= 1'b0;
            mode_q.err_lvl  <= 1'b1;
        end else if (we) begin
            mode_q <= mode_in;
        end
    end

    assign kernel = has_kernel_rights(mode_q);

endmodule

// File: rtl/ksx_boot_pc.sv
module ksx_boot_pc
    import ksx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [VA_W-1:0] next_val,
    output logic [VA_W-1:0] pc_q
);

    always_ff @(posedge clk) begin
        if (rst)     pc_q <= COLD_VEC;
        else if (we) pc_q <= next_val;
    end

endmodule

// File: rtl/ksx_seg_decode.sv
module ksx_seg_decode
    import ksx_pkg::*;
(
    input  logic [VA_W-1:0] vaddr,
    input  logic            kernel,
    output xlat_t           res
);

    logic [N_WIN-1:0]  hit;
    logic [PA_W-1:0]   offs [N_WIN];

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        assign hit[g]  = in_window(vaddr, win_base(g));
        assign offs[g] = strip_base(vaddr, win_base(g));
    end

    always_comb begin
        res = '0;
        if (|hit) begin
            if (kernel) begin
                res.ok     = 1'b1;
                res.cached = hit[0];
                for (int i = 0; i < N_WIN; i++) begin
                    if (hit[i]) res.paddr = offs[i];
                end
            end else begin
                res.addr_err = 1'b1;
            end
        end else begin
            res.needs_tlb = 1'b1;
        end
    end

endmodule

// File: rtl/ksx_translator.sv
module ksx_translator
    import ksx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            stat_we,
    input  logic [1:0]      stat_ksu,
    input  logic            stat_exl,
    input  logic            stat_erl,
    input  logic            pc_we,
    input  logic [VA_W-1:0] pc_next,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    output logic            kernel_mode,
    output logic            err_lvl,
    output logic [VA_W-1:0] fetch_pc,
    output logic            rsp_valid,
    output logic            rsp_ok,
    output logic            rsp_addr_err,
    output logic            rsp_needs_tlb,
    output logic            rsp_cached,
    output logic [PA_W-1:0] rsp_paddr
);

    mode_t mode_new;
    mode_t mode_cur;
    xlat_t xl_comb;
    xlat_t xl_q;

    assign mode_new.priv_lvl = stat_ksu;
    assign mode_new.exc_lvl  = stat_exl;
    assign mode_new.err_lvl  = stat_erl;

    ksx_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .we      (stat_we),
        .mode_in (mode_new),
        .mode_q  (mode_cur),
        .kernel  (kernel_mode)
    );

    ksx_boot_pc u_pc (
        .clk      (clk),
        .rst      (rst),
        .we       (pc_we),
        .next_val (pc_next),
        .pc_q     (fetch_pc)
    );

    ksx_seg_decode u_dec (
        .vaddr  (req_vaddr),
        .kernel (kernel_mode),
        .res    (xl_comb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            xl_q      <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) xl_q <= xl_comb;
        end
    end

    assign err_lvl       = mode_cur.err_lvl;
    assign rsp_ok        = xl_q.ok;
    assign rsp_addr_err  = xl_q.addr_err;
    assign rsp_needs_tlb = xl_q.needs_tlb;
    assign rsp_cached    = xl_q.cached;
    assign rsp_paddr     = xl_q.paddr;

endmodule

// File: rtl/ksx_checker.sv
module ksx_checker
    import ksx_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            stat_we,
    input logic [1:0]      stat_ksu,
    input logic            stat_exl,
    input logic            stat_erl,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic            kernel_mode,
    input logic            err_lvl,
    input logic [VA_W-1:0] fetch_pc,
    input logic            rsp_valid,
    input logic            rsp_ok,
    input logic            rsp_addr_err,
    input logic            rsp_needs_tlb,
    input logic            rsp_cached,
    input logic [PA_W-1:0] rsp_paddr
);

    logic in_kwin;
    assign in_kwin = (req_vaddr[63:32] == 32'hFFFF_FFFF) && (req_vaddr[31:30] == 2'b10);

    assert_boot_state_R2: assert property (@(posedge clk)
        rst |=> (err_lvl && kernel_mode && fetch_pc == COLD_VEC && !rsp_valid));

    assert_mode_load_R1: assert property (@(posedge clk) disable iff (rst)
        stat_we |=> (kernel_mode == ($past(stat_ksu) == 2'b00 || $past(stat_exl) || $past(stat_erl))));

    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_one_outcome_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_ok, rsp_addr_err, rsp_needs_tlb}) == 1);

    assert_denied_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && in_kwin && !kernel_mode) |=> (rsp_addr_err && !rsp_ok && rsp_paddr == '0));

    assert_outside_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !in_kwin) |=> (rsp_needs_tlb && !rsp_cached && rsp_paddr == '0));

    assert_granted_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && in_kwin && kernel_mode) |=> (rsp_ok && rsp_cached == !$past(req_vaddr[29])));

endmodule

bind ksx_translator ksx_checker u_chk (.*);

// File: tb/sim_ksx_translator.sv
module sim_ksx_translator;
    import ksx_pkg::*;

    logic            clk = 1'b0;
    logic            rst;
    logic            stat_we;
    logic [1:0]      stat_ksu;
    logic            stat_exl;
    logic            stat_erl;
    logic            pc_we;
    logic [63:0]     pc_next;
    logic            req_valid;
    logic [63:0]     req_vaddr;
    logic            kernel_mode;
    logic            err_lvl;
    logic [63:0]     fetch_pc;
    logic            rsp_valid;
    logic            rsp_ok;
    logic            rsp_addr_err;
    logic            rsp_needs_tlb;
    logic            rsp_cached;
    logic [28:0]     rsp_paddr;

    always #5 clk = ~clk;

    ksx_translator u0 (.*);

    typedef struct {
        logic        ok;
        logic        err;
        logic        tlb;
        logic        cached;
        logic [28:0] paddr;
        string       tag;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    logic [1:0] m_ksu;
    logic       m_exl;
    logic       m_erl;
    logic       in_reset = 1'b1;

    function automatic exp_t model(input logic [63:0] a, input logic k, input string tag);
        exp_t e;
        logic [63:0] d;
        e.ok = 0; e.err = 0; e.tlb = 0; e.cached = 0; e.paddr = '0; e.tag = tag;
        if (a >= 64'hFFFF_FFFF_8000_0000 && a <= 64'hFFFF_FFFF_BFFF_FFFF) begin
            if (k) begin
                e.ok = 1;
                if (a < 64'hFFFF_FFFF_A000_0000) begin
                    e.cached = 1;
                    d = a - 64'hFFFF_FFFF_8000_0000;
                end else begin
                    d = a - 64'hFFFF_FFFF_A000_0000;
                end
                e.paddr = d[28:0];
            end else begin
                e.err = 1;
            end
        end else begin
            e.tlb = 1;
        end
        return e;
    endfunction

    function automatic logic model_kernel();
        return (m_ksu == 2'b00) || m_exl || m_erl;
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic send(input logic [63:0] a, input string tag);
        @(negedge clk);
        stat_we = 0; pc_we = 0;
        req_valid = 1;
        req_vaddr = a;
        q.push_back(model(a, model_kernel(), tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 0; stat_we = 0; pc_we = 0;
        end
    endtask

    task automatic set_mode(input logic [1:0] k, input logic x, input logic r);
        @(negedge clk);
        req_valid = 0;
        stat_we = 1; stat_ksu = k; stat_exl = x; stat_erl = r;
        m_ksu = k; m_exl = x; m_erl = r;
        @(negedge clk);
        stat_we = 0;
        chk({63'd0, kernel_mode}, {63'd0, model_kernel()}, "R1 kernel_mode");
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_reset = 1; rst = 1; req_valid = 0; stat_we = 0; pc_we = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        m_ksu = 2'b10; m_exl = 0; m_erl = 1;
        chk(fetch_pc, 64'hFFFF_FFFF_BFC0_0000, "R2 fetch_pc after reset");
        chk({63'd0, err_lvl}, 64'd1, "R2 err_lvl after reset");
        chk({63'd0, kernel_mode}, 64'd1, "R2 kernel_mode after reset");
        chk({63'd0, rsp_valid}, 64'd0, "R2 rsp_valid after reset");
        in_reset = 0;
    endtask

    // Scoreboard monitor: compares each response with the oldest expected item
    always @(negedge clk) begin
        if (!in_reset && rsp_valid) begin
            if (q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R8 unexpected response: actual rsp_valid=1 expected 0");
            end else begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (rsp_ok !== e.ok || rsp_addr_err !== e.err || rsp_needs_tlb !== e.tlb ||
                    rsp_cached !== e.cached || rsp_paddr !== e.paddr) begin
                    n_bad++;
                    $display("FAIL %s: actual ok=%b err=%b tlb=%b c=%b pa=%h expected ok=%b err=%b tlb=%b c=%b pa=%h",
                             e.tag, rsp_ok, rsp_addr_err, rsp_needs_tlb, rsp_cached, rsp_paddr,
                             e.ok, e.err, e.tlb, e.cached, e.paddr);
                end
            end
        end else if (!in_reset && q.size() > 0 && !req_valid) begin
            n_cmp++; n_bad++;
            $display("FAIL R8 missing response: actual rsp_valid=0 expected 1");
            void'(q.pop_front());
        end
    end

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1; stat_we = 0; stat_ksu = 0; stat_exl = 0; stat_erl = 0;
        pc_we = 0; pc_next = '0; req_valid = 0; req_vaddr = '0;
        m_ksu = 2'b10; m_exl = 0; m_erl = 1;
        do_reset();

        // R5: boot vector from fetch_pc
        send(fetch_pc, "R5 boot vector");
        idle(1);

        // R3 / R4 boundaries, back to back (R8 ordering)
        send(64'hFFFF_FFFF_A000_0000, "R3 uncached low edge");
        send(64'hFFFF_FFFF_BFFF_FFFF, "R3 uncached high edge");
        send(64'hFFFF_FFFF_A123_4567, "R3 uncached mid");
        send(64'hFFFF_FFFF_8000_0000, "R4 cached low edge");
        send(64'hFFFF_FFFF_9FFF_FFFF, "R4 cached high edge");
        send(64'hFFFF_FFFF_8ABC_DEF0, "R4 cached mid");
        send(64'hFFFF_FFFF_7FFF_FFFF, "R7 below cached");
        send(64'hFFFF_FFFF_C000_0000, "R7 above uncached");
        send(64'h0000_0000_A000_0000, "R7 upper half zero");
        send(64'hFFFF_FFFE_BFC0_0000, "R7 partial upper ones");
        send(64'h0000_0000_0040_0000, "R7 user space");
        idle(2);

        // R1 / R6: user rights
        set_mode(2'b10, 0, 0);
        send(64'hFFFF_FFFF_BFC0_0000, "R6 uncached denied");
        send(64'hFFFF_FFFF_8000_1000, "R6 cached denied");
        send(64'hFFFF_FFFF_C000_0000, "R7 outside in user mode");
        idle(1);
        set_mode(2'b01, 0, 0);
        send(64'hFFFF_FFFF_A000_0040, "R6 supervisor denied");
        idle(1);
        set_mode(2'b10, 1, 0);
        send(64'hFFFF_FFFF_A000_0040, "R1 exception level grants");
        idle(1);
        set_mode(2'b01, 0, 1);
        send(64'hFFFF_FFFF_9000_0004, "R1 error level grants");
        idle(1);
        set_mode(2'b00, 0, 0);
        send(64'hFFFF_FFFF_BFFF_FFFC, "R1 kernel level grants");
        idle(1);

        // R9: request in the same cycle as a mode write uses the old mode
        @(negedge clk);
        stat_we = 1; stat_ksu = 2'b10; stat_exl = 0; stat_erl = 0;
        req_valid = 1; req_vaddr = 64'hFFFF_FFFF_A000_0100;
        q.push_back(model(req_vaddr, model_kernel(), "R9 old mode applies"));
        m_ksu = 2'b10; m_exl = 0; m_erl = 0;
        @(negedge clk);
        stat_we = 0;
        req_vaddr = 64'hFFFF_FFFF_A000_0100;
        q.push_back(model(req_vaddr, model_kernel(), "R9 new mode applies"));
        idle(2);

        // R9: fetch pointer load, then R2: reset restores it
        @(negedge clk);
        pc_we = 1; pc_next = 64'h1234_5678_9ABC_DEF0;
        @(negedge clk);
        pc_we = 0;
        chk(fetch_pc, 64'h1234_5678_9ABC_DEF0, "R9 fetch_pc load");
        do_reset();
        send(fetch_pc, "R5 boot vector after second reset");
        idle(3);

        chk({63'd0, (q.size() == 0)}, 64'd1, "R8 all responses seen");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule